// File: doc/BRIEF.md
# Cartridge Bus Byte-Copy DMA

This block moves bytes between the cartridge side of the system and main DRAM. Software writes a cartridge address and a DRAM address into two registers. It then writes one of two length registers, and that write starts the copy. One length register copies from DRAM to the cartridge side. The other copies from the cartridge side to DRAM. The cartridge address is sorted into windows. A 64 KiB save-RAM window is backed by a 32 KiB battery RAM. A ROM window covers 0x10000000 up to the boot region. The boot region starts at 0x1FC00000. Every other address moves nothing. Each transfer ends in the same way: completion flags are set, and an interrupt is raised after a delay that depends on the window.

ROM copies are the only transfers that are bounds-checked. The byte count is cut so that the copy stays inside the ROM. It is then cut again so that it stays below a DRAM ceiling. A ROM offset or DRAM address that is out of range takes an error path: nothing moves and the interrupt still arrives. The block moves one byte per clock through three byte-wide memory ports, each with its own read and write strobes. Every read port returns its data one clock after the read strobe.

Register map (`reg_addr`): 0 cartridge address, 1 DRAM address, 2 DRAM-to-cart length (start), 3 cart-to-DRAM length (start), 4 status. Status read bits: 0 done, 1 ROM-path, 2 busy, 3 interrupt pending. Writing the status register with bit 0 set clears bits 0, 1 and 3.

Top module: `cart_dma_ctrl`

## Requirements
- R1: After reset, the status reads 0, `irq` is low and no memory strobe is active.
- R2: The byte count of a transfer is bits 23:0 of the written length value plus one; bits 31:24 are ignored.
- R3: A cartridge address in [0x08000000, 0x08010000) selects save RAM in both directions. The save offset is (address − 0x08000000) masked to 16 bits, then taken modulo 32 KiB, and it advances by one per byte.
- R4: Any other cartridge address below 0x10000000 (this includes the ignored window [0x06000000, 0x08000000)) moves no byte. So does any cart address other than a save address in the DRAM-to-cart direction. Each such transfer sets only status bit 0, with delay SLOW_DELAY.
- R5: A cart-to-DRAM transfer from a cartridge address at or above 0x1FC00000 moves no byte, sets only status bit 0 and uses delay SLOW_DELAY.
- R6: A cart-to-DRAM transfer from [0x10000000, 0x1FC00000) copies ROM bytes from offset (address − 0x10000000) masked to 26 bits into consecutive DRAM bytes, and sets status bits 1 and 0.
- R7: If offset + count exceeds ROM_SIZE, the count becomes ROM_SIZE − offset.
- R8: After the ROM clamp, if DRAM address + count exceeds DRAM_TOP, the count becomes DRAM_TOP − DRAM address. The byte at DRAM_TOP is therefore never written by a ROM copy.
- R9: A ROM offset greater than ROM_SIZE, or a DRAM address greater than DRAM_TOP, moves no byte. The transfer still sets status bits 1 and 0 and uses a delay of 0.
- R10: With N bytes moved and delay D, `irq` is first seen high after the (N+2+D)-th rising edge that follows the edge accepting the start write. D is SLOW_DELAY for non-ROM transfers and floor(N/8) for ROM copies.
- R11: Status bit 2 is high from the start edge until the edge that raises `irq`. A length-register write during that time starts nothing.
- R12: Writing the status register with bit 0 set clears the interrupt and status bits 0 and 1.
- R13: A copy moves one byte per clock, with at most one read strobe and at most one write strobe active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Transfer-complete interrupt |
| save_addr | output | SAVE_AW | Save RAM byte address |
| save_rd | output | 1 | Save RAM read strobe |
| save_wr | output | 1 | Save RAM write strobe |
| save_wdata | output | 8 | Save RAM write byte |
| save_rdata | input | 8 | Save RAM read byte (one clock after `save_rd`) |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_rd | output | 1 | ROM read strobe |
| rom_rdata | input | 8 | ROM read byte (one clock after `rom_rd`) |
| dram_addr | output | DRAM_AW | DRAM byte address |
| dram_rd | output | 1 | DRAM read strobe |
| dram_wr | output | 1 | DRAM write strobe |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte (one clock after `dram_rd`) |

## Verification
The bench sweeps ROM offsets and DRAM addresses that sit on the clamp edges: one below, at and one above ROM_SIZE and DRAM_TOP. It pairs them with byte counts that straddle multiples of eight. A design with an off-by-one at either clamp would write one DRAM byte too many, or one too few. A design that mixes up the order of the two clamps, or uses the unclamped count for the delay, would raise the interrupt on the wrong cycle. The save window is exercised at the 32 KiB wrap and with an offset above 0x7FFF; a design without the 16-bit mask and the 15-bit wrap would corrupt the wrong bytes. Addresses in the ignored window, just outside the save window and in the boot region all check that no memory changes. A length write during a running copy checks that no second transfer starts.

// File: rtl/cart_dma_pkg.sv
package cart_dma_pkg;

    // Cartridge address windows
    localparam logic [31:0] SAVE_LO       = 32'h0800_0000;
    localparam logic [31:0] SAVE_HI       = 32'h0801_0000;
    localparam logic [31:0] ROM_BASE      = 32'h1000_0000;
    localparam logic [31:0] BOOT_BASE     = 32'h1FC0_0000;
    localparam logic [31:0] ROM_OFF_MASK  = 32'h03FF_FFFF;
    localparam logic [31:0] SAVE_OFF_MASK = 32'h0000_FFFF;
    localparam logic [31:0] LEN_MASK      = 32'h00FF_FFFF;

    // Register select codes
    localparam logic [2:0] RSEL_CART    = 3'd0;
    localparam logic [2:0] RSEL_DRAM    = 3'd1;
    localparam logic [2:0] RSEL_TO_CART = 3'd2;
    localparam logic [2:0] RSEL_TO_DRAM = 3'd3;
    localparam logic [2:0] RSEL_STATUS  = 3'd4;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_SAVE = 2'd1,
        PORT_ROM  = 2'd2,
        PORT_DRAM = 2'd3
    } port_e;

    typedef struct packed {
        port_e       src;
        port_e       dst;
        logic [31:0] src_base;
        logic [31:0] dst_base;
        logic [31:0] len;
        logic [31:0] delay;
        logic        rom_flag;
    } xfer_plan_t;

    function automatic logic [31:0] byte_count(input logic [31:0] len_reg);
        return (len_reg & LEN_MASK) + 32'd1;
    endfunction

    function automatic logic in_save(input logic [31:0] cart);
        return (cart >= SAVE_LO) && (cart < SAVE_HI);
    endfunction

    // Decode the window and size the transfer from the programmed registers.
    function automatic xfer_plan_t plan_xfer(
        input logic [31:0] cart,
        input logic [31:0] dram,
        input logic [31:0] len_reg,
        input logic        to_dram,
        input logic [31:0] rom_size,
        input logic [31:0] dram_top,
        input logic [31:0] slow_delay
    );
        xfer_plan_t  p;
        logic [31:0] n;
        logic [31:0] off;
        p        = '0;
        p.src    = PORT_NONE;
        p.dst    = PORT_NONE;
        p.delay  = slow_delay;
        n        = byte_count(len_reg);
        off      = (cart - ROM_BASE) & ROM_OFF_MASK;
        if (!to_dram) begin
            if (in_save(cart)) begin
                p.src      = PORT_DRAM;
                p.dst      = PORT_SAVE;
                p.src_base = dram;
                p.dst_base = (cart - SAVE_LO) & SAVE_OFF_MASK;
                p.len      = n;
            end
        end else if (cart < ROM_BASE) begin
            if (in_save(cart)) begin
                p.src      = PORT_SAVE;
                p.dst      = PORT_DRAM;
                p.src_base = (cart - SAVE_LO) & SAVE_OFF_MASK;
                p.dst_base = dram;
                p.len      = n;
            end
        end else if (cart < BOOT_BASE) begin
            p.rom_flag = 1'b1;
            if ((off > rom_size) || (dram > dram_top)) begin
                p.len   = 32'd0;
                p.delay = 32'd0;
            end else begin
                if ((off + n) > rom_size) n = rom_size - off;
                if ((dram + n) > dram_top) n = dram_top - dram;
                p.src      = PORT_ROM;
                p.dst      = PORT_DRAM;
                p.src_base = off;
                p.dst_base = dram;
                p.len      = n;
                p.delay    = n >> 3;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/cart_dma_regs.sv
module cart_dma_regs
    import cart_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        busy,
    input  logic        finish,
    input  logic        finish_rom,
    input  logic        fire,
    output logic [31:0] cart_q,
    output logic [31:0] dram_q,
    output logic        start,
    output logic        start_to_dram,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    logic [31:0] len_to_cart_q;
    logic [31:0] len_to_dram_q;
    logic        st_done;
    logic        st_rom;
    logic        len_sel;
    logic        clr_req;

    assign len_sel       = (reg_addr == RSEL_TO_CART) || (reg_addr == RSEL_TO_DRAM);
    assign start         = reg_wr && len_sel && !busy;
    assign start_to_dram = (reg_addr == RSEL_TO_DRAM);
    assign clr_req       = reg_wr && (reg_addr == RSEL_STATUS) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cart_q        <= '0;
            dram_q        <= '0;
            len_to_cart_q <= '0;
            len_to_dram_q <= '0;
            st_done       <= 1'b0;
            st_rom        <= 1'b0;
            irq           <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RSEL_CART) cart_q <= reg_wdata;
            if (reg_wr && reg_addr == RSEL_DRAM) dram_q <= reg_wdata;
            if (start && !start_to_dram) len_to_cart_q <= reg_wdata;
            if (start &&  start_to_dram) len_to_dram_q <= reg_wdata;
            if (clr_req) begin
                st_done <= 1'b0;
                st_rom  <= 1'b0;
                irq     <= 1'b0;
            end
            if (finish) begin
                st_done <= 1'b1;
                if (finish_rom) st_rom <= 1'b1;
            end
            if (fire) irq <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            RSEL_CART:    reg_rdata = cart_q;
            RSEL_DRAM:    reg_rdata = dram_q;
            RSEL_TO_CART: reg_rdata = len_to_cart_q;
            RSEL_TO_DRAM: reg_rdata = len_to_dram_q;
            RSEL_STATUS:  reg_rdata = {28'd0, irq, busy, st_rom, st_done};
            default:      reg_rdata = 32'd0;
        endcase
    end

    AST_LEN_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(len_to_dram_q) && $stable(len_to_cart_q))); // R11

endmodule

// File: rtl/cart_dma_mover.sv
module cart_dma_mover
    import cart_dma_pkg::*;
#(
    parameter int          SAVE_AW  = 15,
    parameter int          ROM_AW   = 26,
    parameter int          DRAM_AW  = 23,
    parameter logic [31:0] ROM_SIZE = 32'h0100_0000,
    parameter logic [31:0] DRAM_TOP = 32'h007F_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  xfer_plan_t         plan_in,
    input  logic [7:0]         save_rdata,
    input  logic [7:0]         rom_rdata,
    input  logic [7:0]         dram_rdata,
    output logic [SAVE_AW-1:0] save_addr,
    output logic               save_rd,
    output logic               save_wr,
    output logic [7:0]         save_wdata,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               rom_rd,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic               dram_rd,
    output logic               dram_wr,
    output logic [7:0]         dram_wdata,
    output logic               busy,
    output logic               done,
    output logic [31:0]        done_delay,
    output logic               done_rom
);

    xfer_plan_t  cfg;
    logic        active;
    logic        wr_pend;
    logic [31:0] rd_cnt;
    logic        rd_go;
    logic        wr_go;
    logic [31:0] src_full;
    logic [31:0] dst_full;
    logic [7:0]  byte_d;

    assign rd_go    = active && (rd_cnt < cfg.len);
    assign wr_go    = active && wr_pend;
    assign done     = active && (rd_cnt == cfg.len);
    assign src_full = cfg.src_base + rd_cnt;
    assign dst_full = cfg.dst_base + rd_cnt - 32'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            wr_pend <= 1'b0;
            rd_cnt  <= '0;
            cfg     <= '0;
        end else if (start) begin
            active  <= 1'b1;
            wr_pend <= 1'b0;
            rd_cnt  <= '0;
            cfg     <= plan_in;
        end else if (active) begin
            if (done) begin
                active  <= 1'b0;
                wr_pend <= 1'b0;
            end else begin
                rd_cnt  <= rd_cnt + 32'd1;
                wr_pend <= 1'b1;
            end
        end
    end

    // Byte returned by the source port one clock after its read strobe
    always_comb begin
        case (cfg.src)
            PORT_SAVE: byte_d = save_rdata;
            PORT_ROM:  byte_d = rom_rdata;
            PORT_DRAM: byte_d = dram_rdata;
            default:   byte_d = 8'd0;
        endcase
    end

    assign save_rd    = rd_go && (cfg.src == PORT_SAVE);
    assign save_wr    = wr_go && (cfg.dst == PORT_SAVE);
    assign save_addr  = (cfg.src == PORT_SAVE) ? src_full[SAVE_AW-1:0] : dst_full[SAVE_AW-1:0];
    assign save_wdata = byte_d;

    assign rom_rd     = rd_go && (cfg.src == PORT_ROM);
    assign rom_addr   = src_full[ROM_AW-1:0];

    assign dram_rd    = rd_go && (cfg.src == PORT_DRAM);
    assign dram_wr    = wr_go && (cfg.dst == PORT_DRAM);
    assign dram_addr  = (cfg.src == PORT_DRAM) ? src_full[DRAM_AW-1:0] : dst_full[DRAM_AW-1:0];
    assign dram_wdata = byte_d;

    assign busy       = active;
    assign done_delay = cfg.delay;
    assign done_rom   = cfg.rom_flag;

    AST_ROM_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        rom_rd |-> (src_full < ROM_SIZE)); // R7

    AST_DRAM_CEILING: assert property (@(posedge clk) disable iff (rst)
        (dram_wr && cfg.src == PORT_ROM) |-> (dst_full < DRAM_TOP)); // R8

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_go && !start) |=> wr_go); // R13

endmodule

// File: rtl/cart_dma_delay.sv
module cart_dma_delay (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] delay_in,
    output logic        busy,
    output logic        fire
);

    logic [31:0] cnt;

    assign fire = busy && (cnt == 32'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= delay_in;
        end else if (busy) begin
            if (cnt == 32'd0) busy <= 1'b0;
            else              cnt  <= cnt - 32'd1;
        end
    end

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy); // R10

    AST_FIRE_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        fire |=> !busy); // R10

endmodule

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
    import cart_dma_pkg::*;
#(
    parameter int          SAVE_AW    = 15,
    parameter int          ROM_AW     = 26,
    parameter int          DRAM_AW    = 23,
    parameter logic [31:0] ROM_SIZE   = 32'h0100_0000,
    parameter logic [31:0] DRAM_TOP   = 32'h007F_FFFF,
    parameter logic [31:0] SLOW_DELAY = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq,
    output logic [SAVE_AW-1:0] save_addr,
    output logic               save_rd,
    output logic               save_wr,
    output logic [7:0]         save_wdata,
    input  logic [7:0]         save_rdata,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               rom_rd,
    input  logic [7:0]         rom_rdata,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic               dram_rd,
    output logic               dram_wr,
    output logic [7:0]         dram_wdata,
    input  logic [7:0]         dram_rdata
);

    logic [31:0] cart_q;
    logic [31:0] dram_q;
    logic        start;
    logic        start_to_dram;
    logic        mover_busy;
    logic        wait_busy;
    logic        busy;
    logic        done;
    logic [31:0] done_delay;
    logic        done_rom;
    logic        fire;
    xfer_plan_t  plan;

    assign busy = mover_busy || wait_busy;
    assign plan = plan_xfer(cart_q, dram_q, reg_wdata, start_to_dram,
                            ROM_SIZE, DRAM_TOP, SLOW_DELAY);

    cart_dma_regs regs_i (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .busy          (busy),
        .finish        (done),
        .finish_rom    (done_rom),
        .fire          (fire),
        .cart_q        (cart_q),
        .dram_q        (dram_q),
        .start         (start),
        .start_to_dram (start_to_dram),
        .reg_rdata     (reg_rdata),
        .irq           (irq)
    );

    cart_dma_mover #(
        .SAVE_AW  (SAVE_AW),
        .ROM_AW   (ROM_AW),
        .DRAM_AW  (DRAM_AW),
        .ROM_SIZE (ROM_SIZE),
        .DRAM_TOP (DRAM_TOP)
    ) mover_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plan_in    (plan),
        .save_rdata (save_rdata),
        .rom_rdata  (rom_rdata),
        .dram_rdata (dram_rdata),
        .save_addr  (save_addr),
        .save_rd    (save_rd),
        .save_wr    (save_wr),
        .save_wdata (save_wdata),
        .rom_addr   (rom_addr),
        .rom_rd     (rom_rd),
        .dram_addr  (dram_addr),
        .dram_rd    (dram_rd),
        .dram_wr    (dram_wr),
        .dram_wdata (dram_wdata),
        .busy       (mover_busy),
        .done       (done),
        .done_delay (done_delay),
        .done_rom   (done_rom)
    );

    cart_dma_delay delay_i (
        .clk      (clk),
        .rst      (rst),
        .load     (done),
        .delay_in (done_delay),
        .busy     (wait_busy),
        .fire     (fire)
    );

    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({save_rd, rom_rd, dram_rd})); // R13

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({save_wr, dram_wr})); // R13

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(save_rd || save_wr || rom_rd || dram_rd || dram_wr)); // R11

    AST_IRQ_RISES_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy); // R10

endmodule

// File: tb/cart_dma_ctrl_tb_top.sv
module cart_dma_ctrl_tb_top;

    localparam int          SAW   = 15;
    localparam int          RAW   = 26;
    localparam int          DAW   = 11;
    localparam logic [31:0] ROMSZ = 32'd600;
    localparam logic [31:0] DTOP  = 32'h7FF;
    localparam logic [31:0] SLOW  = 32'd64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst;
    logic            reg_wr;
    logic [2:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic            irq;
    logic [SAW-1:0]  save_addr;
    logic            save_rd, save_wr;
    logic [7:0]      save_wdata, save_rdata;
    logic [RAW-1:0]  rom_addr;
    logic            rom_rd;
    logic [7:0]      rom_rdata;
    logic [DAW-1:0]  dram_addr;
    logic            dram_rd, dram_wr;
    logic [7:0]      dram_wdata, dram_rdata;

    cart_dma_ctrl #(
        .SAVE_AW(SAW), .ROM_AW(RAW), .DRAM_AW(DAW),
        .ROM_SIZE(ROMSZ), .DRAM_TOP(DTOP), .SLOW_DELAY(SLOW)
    ) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .save_addr(save_addr), .save_rd(save_rd), .save_wr(save_wr),
        .save_wdata(save_wdata), .save_rdata(save_rdata),
        .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
        .dram_addr(dram_addr), .dram_rd(dram_rd), .dram_wr(dram_wr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    logic [7:0] dram_m [0:2047];
    logic [7:0] rom_m  [0:1023];
    logic [7:0] sram_m [0:32767];
    logic [7:0] exp_dram [0:2047];
    logic [7:0] exp_sram [0:32767];

    // Byte memories: read data registered one clock after the strobe
    always @(posedge clk) begin
        if (dram_rd) dram_rdata <= dram_m[dram_addr];
        if (save_rd) save_rdata <= sram_m[save_addr];
        if (rom_rd)  rom_rdata  <= (rom_addr < 1024) ? rom_m[rom_addr[9:0]] : 8'h00;
        if (dram_wr) dram_m[dram_addr] = dram_wdata;
        if (save_wr) sram_m[save_addr] = save_wdata;
    end

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_errs++;
            n_checks++;
            $display("FAIL R10 watchdog expired actual=%0d expected<=190000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic get_status(output logic [31:0] v);
        reg_addr = 3'd4;
        #1;
        v = reg_rdata;
    endtask

    task automatic cmp_mems(input string tag);
        int md = 0;
        int ms = 0;
        for (int i = 0; i < 2048; i++)  if (dram_m[i] !== exp_dram[i]) md++;
        for (int i = 0; i < 32768; i++) if (sram_m[i] !== exp_sram[i]) ms++;
        chk(md == 0, {tag, " dram contents"}, md, 0);
        chk(ms == 0, {tag, " save ram contents"}, ms, 0);
    endtask

    // Expected effect of one transfer, from the requirements
    task automatic model(input bit to_dram, input logic [31:0] cart, input logic [31:0] dram,
                         input logic [31:0] lreg, output int nb, output int dl, output int st);
        logic [31:0] n   = (lreg & 32'h00FF_FFFF) + 1;
        logic [31:0] off;
        logic [31:0] so  = (cart - 32'h0800_0000) & 32'h0000_FFFF;
        bit save_hit = (cart >= 32'h0800_0000) && (cart < 32'h0801_0000);
        nb = 0; dl = int'(SLOW); st = 1;
        if (!to_dram) begin
            if (save_hit) begin
                for (int i = 0; i < int'(n); i++)
                    exp_sram[(so + i) & 32'h7FFF] = exp_dram[(dram + i) & 32'h7FF];
                nb = int'(n);
            end
        end else if (cart < 32'h1000_0000) begin
            if (save_hit) begin
                for (int i = 0; i < int'(n); i++)
                    exp_dram[(dram + i) & 32'h7FF] = exp_sram[(so + i) & 32'h7FFF];
                nb = int'(n);
            end
        end else if (cart < 32'h1FC0_0000) begin
            off = (cart - 32'h1000_0000) & 32'h03FF_FFFF;
            st  = 3;
            if (off > ROMSZ || dram > DTOP) begin
                nb = 0; dl = 0;
            end else begin
                if (off + n > ROMSZ) n = ROMSZ - off;
                if (dram + n > DTOP) n = DTOP - dram;
                for (int i = 0; i < int'(n); i++)
                    exp_dram[dram + i] = rom_m[off + i];
                nb = int'(n);
                dl = int'(n) / 8;
            end
        end
    endtask

    task automatic run_xfer(input bit to_dram, input logic [31:0] cart, input logic [31:0] dram,
                            input logic [31:0] lreg, input string tag);
        int nb, dl, st, cyc;
        logic [31:0] s;
        reg_write(3'd0, cart);
        reg_write(3'd1, dram);
        model(to_dram, cart, dram, lreg, nb, dl, st);
        reg_write(to_dram ? 3'd3 : 3'd2, lreg);
        get_status(s);
        chk(s[2] == 1'b1, {tag, " R11 busy after start"}, s[2], 1);
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!irq && cyc < 20000);
        chk(cyc == nb + 2 + dl, {tag, " R10 R13 interrupt cycle"}, cyc, nb + 2 + dl);
        get_status(s);
        chk(s[3:0] == 4'(8 | st), {tag, " status flags"}, s[3:0], 8 | st);
        cmp_mems(tag);
        reg_write(3'd4, 32'h1);
        get_status(s);
        chk(s[3:0] == 4'h0 && !irq, {tag, " R12 clear"}, {irq, s[3:0]}, 0);
    endtask

    logic [31:0] st_v;
    int offs [8]  = '{0, 1, 7, 300, 592, 599, 600, 601};
    int lens [6]  = '{1, 8, 9, 17, 64, 200};
    int drams[6]  = '{0, 5, 'h700, 'h7FE, 'h7FF, 'h800};

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
        save_rdata = '0; rom_rdata = '0; dram_rdata = '0;
        for (int i = 0; i < 2048; i++)  begin dram_m[i] = 8'(i ^ 8'hA5); exp_dram[i] = 8'(i ^ 8'hA5); end
        for (int i = 0; i < 1024; i++)  rom_m[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 32768; i++) begin sram_m[i] = 8'(i ^ (i >> 8)); exp_sram[i] = 8'(i ^ (i >> 8)); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        get_status(st_v);
        chk(st_v == 32'd0, "R1 status after reset", st_v, 0);
        chk(!irq && !save_rd && !save_wr && !rom_rd && !dram_rd && !dram_wr,
            "R1 quiet outputs after reset", {irq, save_rd, save_wr, rom_rd, dram_rd, dram_wr}, 0);

        // R2 upper length bits ignored
        run_xfer(1'b1, 32'h1000_0010, 32'h20, 32'hFF00_0003, "R2 length low 24 bits");
        // R6 offset masked to 26 bits
        run_xfer(1'b1, 32'h1400_0005, 32'h40, 32'd11, "R6 offset mask");

        // R3 save window, both directions, with wraps
        run_xfer(1'b1, 32'h0800_0100, 32'h100, 32'd31, "R3 save to dram");
        run_xfer(1'b1, 32'h0800_7FF8, 32'h200, 32'd15, "R3 save wrap at 32 KiB");
        run_xfer(1'b1, 32'h0800_FFF0, 32'h240, 32'd7,  "R3 save offset above 0x7FFF");
        run_xfer(1'b0, 32'h0800_0400, 32'h10,  32'd39, "R3 dram to save");
        run_xfer(1'b0, 32'h0800_7FFC, 32'h60,  32'd7,  "R3 dram to save wrap");

        // R4 windows that move nothing
        run_xfer(1'b1, 32'h0600_0000, 32'h80, 32'd15, "R4 ignored window low edge");
        run_xfer(1'b1, 32'h07FF_FFFF, 32'h80, 32'd15, "R4 ignored window high edge");
        run_xfer(1'b1, 32'h0000_1000, 32'h80, 32'd15, "R4 unmapped low address");
        run_xfer(1'b1, 32'h0801_0000, 32'h80, 32'd15, "R4 just past save window");
        run_xfer(1'b0, 32'h1000_0000, 32'h80, 32'd15, "R4 to cart from rom window");
        run_xfer(1'b0, 32'h0600_0000, 32'h80, 32'd15, "R4 to cart ignored window");

        // R5 boot region
        run_xfer(1'b1, 32'h1FC0_0000, 32'h90, 32'd15, "R5 boot region start");
        run_xfer(1'b1, 32'h1FC0_07C0, 32'h90, 32'd63, "R5 boot region inside");
        run_xfer(1'b1, 32'hFFFF_FFF0, 32'h90, 32'd3,  "R5 boot region top");

        // R6 R7 R8 R9 sweep of ROM offsets, counts and DRAM addresses
        foreach (offs[a]) foreach (lens[b]) foreach (drams[c]) begin
            logic [31:0] o = offs[a];
            logic [31:0] n = lens[b];
            logic [31:0] d = drams[c];
            string tg;
            if (o > ROMSZ || d > DTOP)      tg = "R9 rom error path";
            else if (o + n > ROMSZ)         tg = "R7 rom end clamp";
            else if (d + n > DTOP)          tg = "R8 dram ceiling clamp";
            else                            tg = "R6 rom copy";
            run_xfer(1'b1, 32'h1000_0000 + o, d, n - 1, tg);
        end

        // R11 start write while busy is ignored
        begin
            int nb, dl, st, cyc;
            reg_write(3'd0, 32'h0800_0000);
            reg_write(3'd1, 32'h300);
            model(1'b1, 32'h0800_0000, 32'h300, 32'd39, nb, dl, st);
            reg_write(3'd3, 32'd39);
            repeat (3) @(negedge clk);
            reg_write(3'd2, 32'd15);
            get_status(st_v);
            chk(st_v[2] == 1'b1, "R11 still busy after ignored start", st_v[2], 1);
            cyc = 0;
            do begin @(posedge clk); cyc++; @(negedge clk); end while (!irq && cyc < 20000);
            cmp_mems("R11 ignored start");
            reg_write(3'd4, 32'h1);
            repeat (150) @(negedge clk);
            get_status(st_v);
            chk(st_v[3:0] == 4'h0 && !irq, "R11 no second transfer", {irq, st_v[3:0]}, 0);
            cmp_mems("R11 after idle wait");
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule